// File: doc/BRIEF.md
# Guarded True Dual-Port RAM

A single-clock memory with two symmetric access ports, A and B, over one shared word array. On every rising edge each port performs either a read (no write-enable bits set) or a byte-masked write at any address. The registered read data of each port appears after that edge. Each port has a build-time mode that fixes what its output register captures on a cycle in which it writes. It also fixes what the port sees when the other port writes the address it is reading.

Same-cycle, same-address writes from both ports are never allowed to mix in the array. A guard inside the block admits exactly one of the two writes and raises a collision output in that cycle. The winner alternates from one collision to the next. Writes to different addresses, and all reads, never interfere with each other. The ports are plain, always-accepting memory pins: there is no handshake and no back-pressure, and every request is served on the edge that samples it.

Top module: `dpram_guarded`

## Requirements
- R1: Read latency is one cycle. A port with all write enables low loads its read data register, at the next rising edge, with the word stored at its address before that edge.
- R2: In read-first mode (`WM_READ_FIRST`), a port whose write lands loads its read data with the word held at that address before the write.
- R3: In write-first mode (`WM_WRITE_FIRST`), a port whose write lands loads its read data with the post-write word. That word takes the written lanes from the write data and the unwritten lanes from the previous contents.
- R4: In no-change mode (`WM_NO_CHANGE`), a port's read data register keeps its value on every cycle in which that port's write lands.
- R5: Write-enable bit i covers data bits [8i+7:8i]. Only enabled lanes change in the array, and the other lanes keep their contents.
- R6: When one port's write lands at the address the other port reads in the same cycle, a write-first reader gets the post-write word. A read-first or no-change reader gets the old word.
- R7: `collision` is high, in the same cycle and combinationally, exactly when both ports have at least one write-enable bit set and equal addresses. On such a cycle, only the winning port's enabled lanes are written, and the losing port's data does not reach the array.
- R8: The first collision after reset is won by port A. Each later collision is won by the port that lost the previous one. The losing port's read data follows its mode as if it had issued a read.
- R9: Accesses to different addresses are independent. Two writes to different addresses both land, and `collision` stays low.
- R10: While `rst_n` is low at a rising edge, both read data registers clear to zero and the collision priority returns to port A. The array contents are kept.
- R11: When both ports read the same address in the same cycle, both read data outputs get the same stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_we | input | DATA_W/8 | Port A per-lane write enables; all zero means read |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_we | input | DATA_W/8 | Port B per-lane write enables; all zero means read |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| collision | output | 1 | High in a cycle where both ports write the same address |

## Verification
The bench builds two copies at DATA_W=32 and ADDR_W=4, so four byte lanes and sixteen words, and drives both with the same stimulus. One copy runs port A write-first and port B read-first. Each cross-port transfer then goes between two different modes, so forwarding and old-value reads show up in the same cycle. The second copy runs both ports in no-change mode to expose output holding. Partial lane masks on colliding writes show that only the winner's lanes land. A reset placed between collisions shows the priority returning to port A while the stored words survive.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Behaviour of a port's read register on a cycle where it writes.
  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/dpram_lane_merge.sv
// Combinational byte-lane overlay: each lane set in the mask takes the
// write data, the others keep the base word.
module dpram_lane_merge #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  mask,
  output logic [DATA_W-1:0] merged
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = mask[l] ? din[l*LANE_W +: LANE_W]
                                                : base[l*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/dpram_guard.sv
// Write-write guard: detects both ports writing the same word and lets
// exactly one through, alternating the winner between collisions.
module dpram_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  input  logic same_addr,
  output logic clash,
  output logic grant_a,
  output logic grant_b
);

  logic b_turn;  // 0: port A wins the next collision

  assign clash   = req_a & req_b & same_addr;
  assign grant_a = req_a & ~(clash & b_turn);
  assign grant_b = req_b & ~(clash & ~b_turn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_turn <= 1'b0;
    end else if (clash) begin
      b_turn <= ~b_turn;
    end
  end

endmodule

// File: rtl/dpram_out_port.sv
// Read data register of one port with its write-cycle behaviour.
module dpram_out_port
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter wmode_e      MODE   = WM_READ_FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_wr,    // this port's write lands
  input  logic              fwd_hit,   // other port's write lands here
  input  logic [DATA_W-1:0] old_word,  // contents before the edge
  input  logic [DATA_W-1:0] new_word,  // contents after the edge
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] next_q;
  logic              hold;

  always_comb begin
    next_q = old_word;
    hold   = 1'b0;
    if (own_wr) begin
      case (MODE)
        WM_WRITE_FIRST: next_q = new_word;
        WM_NO_CHANGE:   hold   = 1'b1;
        default:        next_q = old_word;
      endcase
    end else if (fwd_hit && MODE == WM_WRITE_FIRST) begin
      next_q = new_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (!hold) begin
      rdata <= next_q;
    end
  end

endmodule

// File: rtl/dpram_guarded.sv
module dpram_guarded
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter wmode_e      MODE_A = WM_READ_FIRST,
  parameter wmode_e      MODE_B = WM_READ_FIRST,
  localparam int unsigned LANE_W = 8,
  localparam int unsigned LANES  = DATA_W / LANE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [LANES-1:0]  b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              collision
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Per-port views, index 0 = A, 1 = B.
  logic [LANES-1:0]  we_v    [NUM_PORTS];
  logic [ADDR_W-1:0] addr_v  [NUM_PORTS];
  logic [DATA_W-1:0] din_v   [NUM_PORTS];
  logic [DATA_W-1:0] rdata_v [NUM_PORTS];
  logic [DATA_W-1:0] old_v   [NUM_PORTS];
  logic [DATA_W-1:0] stage_v [NUM_PORTS];
  logic [DATA_W-1:0] new_v   [NUM_PORTS];
  logic              grant_v [NUM_PORTS];

  logic same_addr;
  logic grant_a;
  logic grant_b;

  assign we_v[0]   = a_we;
  assign we_v[1]   = b_we;
  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;
  assign din_v[0]  = a_wdata;
  assign din_v[1]  = b_wdata;
  assign a_rdata   = rdata_v[0];
  assign b_rdata   = rdata_v[1];
  assign grant_v[0] = grant_a;
  assign grant_v[1] = grant_b;

  assign same_addr = (a_addr == b_addr);

  dpram_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_a     (|a_we),
    .req_b     (|b_we),
    .same_addr (same_addr),
    .clash     (collision),
    .grant_a   (grant_a),
    .grant_b   (grant_b)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned Q  = NUM_PORTS - 1 - p;
    localparam wmode_e      PM = (p == 0) ? MODE_A : MODE_B;

    logic [LANES-1:0] own_mask;
    logic [LANES-1:0] other_mask;
    logic             fwd_hit;

    assign old_v[p]   = mem[addr_v[p]];
    assign own_mask   = grant_v[p] ? we_v[p] : '0;
    assign fwd_hit    = grant_v[Q] & same_addr;
    assign other_mask = fwd_hit ? we_v[Q] : '0;

    // Own lanes first, then any lanes the other port lands here.
    dpram_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_own (
      .base   (old_v[p]),
      .din    (din_v[p]),
      .mask   (own_mask),
      .merged (stage_v[p])
    );

    dpram_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_other (
      .base   (stage_v[p]),
      .din    (din_v[Q]),
      .mask   (other_mask),
      .merged (new_v[p])
    );

    dpram_out_port #(.DATA_W(DATA_W), .MODE(PM)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .own_wr   (grant_v[p]),
      .fwd_hit  (fwd_hit),
      .old_word (old_v[p]),
      .new_word (new_v[p]),
      .rdata    (rdata_v[p])
    );
  end

  // Array update: the guard ensures two granted writes never share a word.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (grant_v[p]) begin
        mem[addr_v[p]] <= stage_v[p];
      end
    end
  end

endmodule

// File: rtl/dpram_checker.sv
module dpram_checker
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter wmode_e      MODE_A = WM_READ_FIRST,
  parameter wmode_e      MODE_B = WM_READ_FIRST,
  localparam int unsigned LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LANES-1:0]  a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_rdata,
  input logic [LANES-1:0]  b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_rdata,
  input logic              collision,
  input logic              grant_a,
  input logic              grant_b
);

  logic seen_clash;
  logic last_won_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_clash <= 1'b0;
      last_won_a <= 1'b0;
    end else if (collision) begin
      seen_clash <= 1'b1;
      last_won_a <= grant_a;
    end
  end

  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> (|a_we && |b_we && a_addr == b_addr));

  p_flag_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|a_we && |b_we && a_addr == b_addr) |-> collision);

  p_one_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> $onehot({grant_a, grant_b}));

  p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_a |-> |a_we) and (grant_b |-> |b_we));

  p_free_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr != b_addr) |-> (grant_a == |a_we && grant_b == |b_we));

  p_first_to_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && !seen_clash) |-> grant_a);

  p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && seen_clash) |-> (grant_a == !last_won_a));

  if (MODE_A == WM_NO_CHANGE) begin : g_hold_a
    p_hold_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant_a |=> $stable(a_rdata));
  end

  if (MODE_B == WM_NO_CHANGE) begin : g_hold_b
    p_hold_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant_b |=> $stable(b_rdata));
  end

endmodule

bind dpram_guarded dpram_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .MODE_A (MODE_A),
  .MODE_B (MODE_B)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_we      (a_we),
  .a_addr    (a_addr),
  .a_rdata   (a_rdata),
  .b_we      (b_we),
  .b_addr    (b_addr),
  .b_rdata   (b_rdata),
  .collision (collision),
  .grant_a   (grant_a),
  .grant_b   (grant_b)
);

// File: tb/dpram_guarded_test.sv
module dpram_guarded_test;
  import dpram_pkg::*;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned NL = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] a_we = '0, b_we = '0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] ra, rb, ra2, rb2;
  logic          coll, coll2, coll_seen;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  // Write-first A, read-first B.
  dpram_guarded #(.DATA_W(DW), .ADDR_W(AW),
                  .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(ra),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rb),
    .collision(coll));

  // No-change on both ports.
  dpram_guarded #(.DATA_W(DW), .ADDR_W(AW),
                  .MODE_A(WM_NO_CHANGE), .MODE_B(WM_NO_CHANGE)) uut_nc (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(ra2),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rb2),
    .collision(coll2));

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock of stimulus; collision sampled mid-cycle, outputs after edge.
  task automatic cyc(input logic [NL-1:0] wa, input logic [AW-1:0] aa,
                     input logic [DW-1:0] da, input logic [NL-1:0] wb,
                     input logic [AW-1:0] ab, input logic [DW-1:0] db);
    @(negedge clk);
    a_we = wa; a_addr = aa; a_wdata = da;
    b_we = wb; b_addr = ab; b_wdata = db;
    #1 coll_seen = coll & coll2;
    @(posedge clk);
    #1;
  endtask

  task automatic read_both(input logic [AW-1:0] aa, input logic [AW-1:0] ab);
    cyc('0, aa, '0, '0, ab, '0);
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0;
    a_we = '0; b_we = '0;
    @(posedge clk); @(posedge clk); #1;
    check("R10 reset a_rdata", ra, '0);
    check("R10 reset b_rdata", rb, '0);
    check("R10 reset nc a_rdata", ra2, '0);
    check("R10 reset nc b_rdata", rb2, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_fill;
    cyc(4'hF, 4'd0, 32'hA0A0A0A0, 4'hF, 4'd1, 32'hB1B1B1B1);
    check("R9 no collision on distinct writes", {31'd0, coll_seen}, '0);
    check("R3 write-first own write", ra, 32'hA0A0A0A0);
    check("R4 no-change hold A", ra2, '0);
    check("R4 no-change hold B", rb2, '0);
    read_both(4'd1, 4'd0);
    check("R9 A reads B's word", ra, 32'hB1B1B1B1);
    check("R1 B reads A's word", rb, 32'hA0A0A0A0);
    check("R1 nc A read", ra2, 32'hB1B1B1B1);
  endtask

  task automatic t_read_first_lanes;
    cyc('0, 4'd1, '0, 4'b0011, 4'd0, 32'h55555555);
    check("R2 read-first own write old", rb, 32'hA0A0A0A0);
    read_both(4'd0, 4'd0);
    check("R5 lane merge", ra, 32'hA0A05555);
    check("R11 same-address read", rb, ra);
    check("R11 nc same-address read", rb2, 32'hA0A05555);
  endtask

  task automatic t_write_first_partial;
    cyc(4'b1000, 4'd1, 32'hCC000000, '0, 4'd0, '0);
    check("R3 write-first partial", ra, 32'hCCB1B1B1);
    check("R1 B read", rb, 32'hA0A05555);
    check("R4 no-change hold on partial", ra2, 32'hA0A05555);
  endtask

  task automatic t_cross_port;
    cyc(4'hF, 4'd0, 32'h01020304, '0, 4'd0, '0);
    check("R7 no flag write vs read", {31'd0, coll_seen}, '0);
    check("R3 A own write", ra, 32'h01020304);
    check("R6 read-first reader gets old", rb, 32'hA0A05555);
    check("R6 nc reader gets old", rb2, 32'hA0A05555);
    cyc('0, 4'd1, '0, 4'hF, 4'd1, 32'h0BADBEEF);
    check("R6 write-first reader forwarded", ra, 32'h0BADBEEF);
    check("R2 B own write old", rb, 32'hCCB1B1B1);
    check("R6 nc A reader old", ra2, 32'hCCB1B1B1);
    check("R4 nc B holds", rb2, 32'hA0A05555);
  endtask

  task automatic t_collisions;
    cyc(4'hF, 4'd0, 32'hAAAAAAAA, 4'hF, 4'd0, 32'hBBBBBBBB);
    check("R7 flag on write-write", {31'd0, coll_seen}, 32'd1);
    check("R8 A wins first, own write", ra, 32'hAAAAAAAA);
    check("R8 loser B reads old", rb, 32'h01020304);
    check("R8 nc loser B reads old", rb2, 32'h01020304);
    read_both(4'd0, 4'd0);
    check("R8 first collision kept A data", rb, 32'hAAAAAAAA);
    cyc(4'b0001, 4'd0, 32'h11111111, 4'b0110, 4'd0, 32'h22222222);
    check("R7 flag on partial collision", {31'd0, coll_seen}, 32'd1);
    check("R8 loser A forwarded", ra, 32'hAA2222AA);
    check("R2 winner B old", rb, 32'hAAAAAAAA);
    check("R8 nc loser A old", ra2, 32'hAAAAAAAA);
    read_both(4'd0, 4'd0);
    check("R7 only winner lanes land", ra, 32'hAA2222AA);
    check("R7 nc array matches", rb2, 32'hAA2222AA);
    cyc(4'hF, 4'd1, 32'h33333333, 4'hF, 4'd1, 32'h44444444);
    read_both(4'd1, 4'd1);
    check("R8 third collision A wins", rb, 32'h33333333);
  endtask

  task automatic t_reset_priority;
    t_reset();
    read_both(4'd1, 4'd1);
    check("R10 array kept over reset", ra, 32'h33333333);
    cyc(4'hF, 4'd3, 32'h5A5A5A5A, 4'hF, 4'd3, 32'hA5A5A5A5);
    read_both(4'd3, 4'd3);
    check("R10 priority back to A", rb, 32'h5A5A5A5A);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_read_first_lanes();
    t_write_first_partial();
    t_cross_port();
    t_collisions();
    t_reset_priority();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule